// File: doc/BRIEF.md
# Timer Capture Channel

This block is one capture/compare channel bundled with the up-counter it samples. The timer clock is not a separate clock. It reaches the block as two one-cycle strobes in the system clock domain: one marks the rising phase of the timer clock and one marks its falling phase. The counter advances on rising-phase strobes while the run input is high. Software can load the counter, and a loaded value is never bumped on the same phase as the load.

In capture mode, an asynchronous edge on the capture input is synchronised and held as pending. It is armed only on a falling-phase strobe. At the next rising-phase strobe the counter value is copied into the channel register. The interrupt flag goes high in that same cycle, and the armed state is dropped.

In compare mode, a rising-phase strobe that finds the counter equal to the channel register raises the flag. A flag set that collides with a CPU read or write of the channel register is held back and applied later, so it is never lost. A flag set is also never split from its capture data. Reading the vector address clears the flag. A capture that lands while the flag is still up sets a sticky overflow bit.

Top module: `tmr_cap_chan`

## Requirements
- R1: After reset the counter, the channel register, the flag and the overflow bit are all zero.
- R2: The counter increments by one on each rising-phase strobe while run_i is high. It holds on falling-phase strobes and while run_i is low, and it resumes at the first rising-phase strobe after run_i returns high.
- R3: A write to address 0 loads the counter. A rising-phase strobe in the same cycle does not increment it, and the next rising-phase strobe increments the loaded value.
- R4: In capture mode, a rising edge on cap_i takes effect only after a falling-phase strobe. A rising-phase strobe with no falling-phase strobe since the edge captures nothing.
- R5: At the first rising-phase strobe after a capture is armed, the channel register (address 1) receives the counter value held just before that strobe, and flag_o rises in the same cycle.
- R6: The armed capture is dropped when it is taken, so later rising-phase strobes without a new edge capture nothing. A cycle with cmp_mode_i high also drops any pending or armed capture.
- R7: A capture or compare hit that coincides with a CPU read or write of address 1 is deferred to the first cycle with no such access. The flag and the channel register are then updated together in that cycle.
- R8: A read of address 3 returns 16'h0002 while the flag is set and 0 otherwise. It clears the flag at that clock edge, whether or not a timer strobe is active.
- R9: A write to address 2 sets the flag from bit 0 and the overflow bit from bit 1. A hardware flag set in the same cycle wins over a software clear.
- R10: A capture applied while the flag is already set sets ovf_o, which stays set until software writes bit 1 of address 2 to zero.
- R11: In compare mode, a rising-phase strobe where the counter (before its increment) equals the channel register sets the flag.
- R12: Address 2 reads back {ovf, flag} in bits 1:0. reg_rdata_o is zero whenever reg_rd_i is low.

Other read encodings: address 0 reads the counter and address 1 reads the channel register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | Counter run enable (low = halted) |
| tclk_rise_i | input | 1 | Timer clock rising-phase strobe |
| tclk_fall_i | input | 1 | Timer clock falling-phase strobe |
| cap_i | input | 1 | Asynchronous capture input |
| cmp_mode_i | input | 1 | 1 = compare mode, 0 = capture mode |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 2 | 0 counter, 1 channel, 2 status, 3 vector |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data (combinational) |
| flag_o | output | 1 | Interrupt flag |
| ovf_o | output | 1 | Sticky capture overflow |

## Verification
Counter, channel register, flag and overflow results all appear at the clock edge that samples the causing strobe or access. The bench therefore drives each input on a falling system-clock edge and checks one falling edge later.

A capture edge needs three register stages to become pending. The bench waits four cycles before issuing the falling-phase strobe.

A deferred capture (R7) lands one edge after the colliding access ends. The bench checks the flag both at the colliding cycle, where it must still be low, and at the following one.

Read data is combinational. The bench samples it shortly after driving the address and drops the read strobe before the next edge, so these peeks do not count as accesses.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    A_CNT  = 2'd0,
    A_CCR  = 2'd1,
    A_STAT = 2'd2,
    A_VEC  = 2'd3
  } tmr_addr_e;
endpackage

// File: rtl/tmr_cnt.sv
module tmr_cnt #(
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          rise_i,
  input  logic          load_i,
  input  logic [CW-1:0] ld_val_i,
  output logic [CW-1:0] cnt_o
);
  logic [CW-1:0] cnt_q;

  // load wins: a loaded value is never bumped on the same phase
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (load_i)           cnt_q <= ld_val_i;
    else if (rise_i && run_i)  cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  // R2
  cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !(rise_i && run_i)) |=> cnt_q == $past(cnt_q));
  // R3
  cnt_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cnt_q == $past(ld_val_i));
endmodule

// File: rtl/tmr_cap.sv
module tmr_cap #(
  parameter int CW = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cap_i,
  input  logic          rise_i,
  input  logic          fall_i,
  input  logic          cmp_mode_i,
  input  logic [CW-1:0] cnt_i,
  input  logic          busy_i,
  input  logic          cpu_wr_i,
  input  logic [CW-1:0] wdata_i,
  output logic [CW-1:0] ccr_o,
  output logic          set_o,
  output logic          set_cap_o
);
  localparam int SL = SYNC_STAGES + 1;

  logic [SL-1:0] sync_q;
  logic          edge_w, pend_q, latch_q;
  logic          take_w, hit_w, req_w, apply_w, src_cap_w;
  logic          held_q, held_cap_q;
  logic [CW-1:0] held_val_q, src_val_w, ccr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[SL-2:0], cap_i};
  end

  assign edge_w = sync_q[SL-2] & ~sync_q[SL-1];

  // pending edge -> armed on falling phase -> taken on rising phase
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         pend_q <= 1'b0;
    else if (cmp_mode_i) pend_q <= 1'b0;
    else if (fall_i)     pend_q <= 1'b0;
    else if (edge_w)     pend_q <= 1'b1;
  end

  assign take_w = rise_i & latch_q & ~cmp_mode_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        latch_q <= 1'b0;
    else if (cmp_mode_i || take_w)      latch_q <= 1'b0;
    else if (fall_i && (pend_q || edge_w)) latch_q <= 1'b1;
  end

  assign hit_w     = cmp_mode_i & rise_i & (cnt_i == ccr_q);
  assign req_w     = take_w | hit_w;
  assign apply_w   = ~busy_i & (req_w | held_q);
  assign src_cap_w = req_w ? take_w : held_cap_q;
  assign src_val_w = req_w ? cnt_i  : held_val_q;

  // collision hold: request parked while CPU touches the channel register
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      held_q     <= 1'b0;
      held_cap_q <= 1'b0;
      held_val_q <= '0;
    end else if (busy_i && req_w) begin
      held_q     <= 1'b1;
      held_cap_q <= take_w;
      held_val_q <= cnt_i;
    end else if (apply_w) begin
      held_q     <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   ccr_q <= '0;
    else if (cpu_wr_i)             ccr_q <= wdata_i;
    else if (apply_w && src_cap_w) ccr_q <= src_val_w;
  end

  assign ccr_o     = ccr_q;
  assign set_o     = apply_w;
  assign set_cap_o = apply_w & src_cap_w;

  // R6
  latch_cmp_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_mode_i |=> !latch_q);
  // R5
  cap_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_w && !busy_i) |=> ccr_q == $past(cnt_i));
  // R7
  held_apply_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (held_q && !busy_i && !req_w) |=> !held_q);
  // R7
  park_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && req_w) |=> held_q);
endmodule

// File: rtl/tmr_flag.sv
module tmr_flag (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       set_i,
  input  logic       set_cap_i,
  input  logic       vec_rd_i,
  input  logic       sw_wr_i,
  input  logic [1:0] sw_val_i,
  output logic       flag_o,
  output logic       ovf_o
);
  logic flag_q, ovf_q;

  // hardware set has priority over any clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       flag_q <= 1'b0;
    else if (set_i)    flag_q <= 1'b1;
    else if (vec_rd_i) flag_q <= 1'b0;
    else if (sw_wr_i)  flag_q <= sw_val_i[0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   ovf_q <= 1'b0;
    else if (set_cap_i && flag_q)  ovf_q <= 1'b1;
    else if (sw_wr_i)              ovf_q <= sw_val_i[1];
  end

  assign flag_o = flag_q;
  assign ovf_o  = ovf_q;

  // R9
  hw_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> flag_q);
  // R10
  ovf_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_cap_i && flag_q) |=> ovf_q);
  // R8
  vec_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_rd_i && !set_i) |=> !flag_q);
endmodule

// File: rtl/tmr_cap_chan.sv
module tmr_cap_chan #(
  parameter int CW = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          tclk_rise_i,
  input  logic          tclk_fall_i,
  input  logic          cap_i,
  input  logic          cmp_mode_i,
  input  logic          reg_wr_i,
  input  logic          reg_rd_i,
  input  logic [1:0]    reg_addr_i,
  input  logic [CW-1:0] reg_wdata_i,
  output logic [CW-1:0] reg_rdata_o,
  output logic          flag_o,
  output logic          ovf_o
);
  import tmr_pkg::*;

  localparam logic [CW-1:0] VEC_CODE = CW'(2);

  tmr_addr_e     addr_w;
  logic [CW-1:0] cnt_w, ccr_w;
  logic          set_w, set_cap_w, flag_w, ovf_w;
  logic          ld_w, ccr_wr_w, busy_w, stat_wr_w, vec_rd_w;

  assign addr_w    = tmr_addr_e'(reg_addr_i);
  assign ld_w      = reg_wr_i && (addr_w == A_CNT);
  assign ccr_wr_w  = reg_wr_i && (addr_w == A_CCR);
  assign busy_w    = (reg_wr_i || reg_rd_i) && (addr_w == A_CCR);
  assign stat_wr_w = reg_wr_i && (addr_w == A_STAT);
  assign vec_rd_w  = reg_rd_i && (addr_w == A_VEC);

  tmr_cnt #(.CW(CW)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run_i),
    .rise_i   (tclk_rise_i),
    .load_i   (ld_w),
    .ld_val_i (reg_wdata_i),
    .cnt_o    (cnt_w)
  );

  tmr_cap #(.CW(CW), .SYNC_STAGES(SYNC_STAGES)) u_cap (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cap_i      (cap_i),
    .rise_i     (tclk_rise_i),
    .fall_i     (tclk_fall_i),
    .cmp_mode_i (cmp_mode_i),
    .cnt_i      (cnt_w),
    .busy_i     (busy_w),
    .cpu_wr_i   (ccr_wr_w),
    .wdata_i    (reg_wdata_i),
    .ccr_o      (ccr_w),
    .set_o      (set_w),
    .set_cap_o  (set_cap_w)
  );

  tmr_flag u_flag (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (set_w),
    .set_cap_i (set_cap_w),
    .vec_rd_i  (vec_rd_w),
    .sw_wr_i   (stat_wr_w),
    .sw_val_i  (reg_wdata_i[1:0]),
    .flag_o    (flag_w),
    .ovf_o     (ovf_w)
  );

  always_comb begin
    reg_rdata_o = '0;
    if (reg_rd_i) begin
      unique case (addr_w)
        A_CNT:  reg_rdata_o = cnt_w;
        A_CCR:  reg_rdata_o = ccr_w;
        A_STAT: reg_rdata_o = {{(CW-2){1'b0}}, ovf_w, flag_w};
        A_VEC:  reg_rdata_o = flag_w ? VEC_CODE : '0;
      endcase
    end
  end

  assign flag_o = flag_w;
  assign ovf_o  = ovf_w;

  // R12
  rd_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_rd_i |-> reg_rdata_o == '0);
endmodule

// File: tb/sim_tmr_cap_chan.sv
module sim_tmr_cap_chan;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run = 1'b0, rise = 1'b0, fall = 1'b0, cap = 1'b0, cmp = 1'b0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [1:0]  addr = '0;
  logic [15:0] wdata = '0, rdata;
  logic        flag, ovf;
  int          errors = 0, checks = 0;
  logic [15:0] snap;

  always #10 clk = ~clk;

  tmr_cap_chan u0 (
    .clk_i(clk), .rst_ni(rst_n), .run_i(run), .tclk_rise_i(rise),
    .tclk_fall_i(fall), .cap_i(cap), .cmp_mode_i(cmp), .reg_wr_i(wr),
    .reg_rd_i(rd), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .flag_o(flag), .ovf_o(ovf)
  );

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  // combinational peek: strobe dropped before the edge, so no access occurs
  task automatic peek(logic [1:0] a, output logic [15:0] v);
    rd = 1'b1; addr = a; #1; v = rdata; rd = 1'b0;
  endtask

  task automatic wreg(logic [1:0] a, logic [15:0] d);
    wr = 1'b1; addr = a; wdata = d; cyc(1); wr = 1'b0;
  endtask

  task automatic rise_p(); rise = 1'b1; cyc(1); rise = 1'b0; endtask
  task automatic fall_p(); fall = 1'b1; cyc(1); fall = 1'b0; endtask
  task automatic cap_edge(); cap = 1'b1; cyc(4); cap = 1'b0; cyc(3); endtask

  task automatic t_reset();
    logic [15:0] v;
    peek(2'd0, v); chk("R1 cnt", v, 16'h0);
    peek(2'd1, v); chk("R1 ccr", v, 16'h0);
    chk("R1 flag", {15'b0, flag}, 16'h0);
    chk("R1 ovf", {15'b0, ovf}, 16'h0);
    chk("R12 idle rdata", rdata, 16'h0);
  endtask

  task automatic t_count();
    logic [15:0] v;
    run = 1'b1;
    rise_p(); rise_p(); rise_p();
    peek(2'd0, v); chk("R2 three rises", v, 16'd3);
    fall_p(); fall_p();
    peek(2'd0, v); chk("R2 fall no count", v, 16'd3);
    run = 1'b0; rise_p(); rise_p();
    peek(2'd0, v); chk("R2 halted", v, 16'd3);
    run = 1'b1; rise_p();
    peek(2'd0, v); chk("R2 resume", v, 16'd4);
  endtask

  task automatic t_load();
    logic [15:0] v;
    rise = 1'b1; wreg(2'd0, 16'h1234); rise = 1'b0;
    peek(2'd0, v); chk("R3 load no bump", v, 16'h1234);
    rise_p();
    peek(2'd0, v); chk("R3 next rise", v, 16'h1235);
  endtask

  task automatic t_capture();
    logic [15:0] v;
    cap_edge(); fall_p();
    peek(2'd0, snap);
    rise_p();
    chk("R5 flag with data", {15'b0, flag}, 16'h1);
    peek(2'd1, v); chk("R5 ccr", v, snap);
    rise_p();
    chk("R6 no recapture ovf", {15'b0, ovf}, 16'h0);
    peek(2'd1, v); chk("R6 ccr kept", v, snap);
    peek(2'd3, v); chk("R8 vector", v, 16'h0002);
    peek(2'd2, v); chk("R12 status", v, 16'h0001);
    rd = 1'b1; addr = 2'd3; rise = 1'b1; cyc(1); rd = 1'b0; rise = 1'b0;
    chk("R8 clear under strobe", {15'b0, flag}, 16'h0);
    peek(2'd3, v); chk("R8 vector empty", v, 16'h0);
  endtask

  task automatic t_nofall();
    cap_edge(); rise_p();
    chk("R4 no fall no capture", {15'b0, flag}, 16'h0);
    fall_p(); rise_p();
    chk("R4 after fall", {15'b0, flag}, 16'h1);
  endtask

  task automatic t_ovf();
    cap_edge(); fall_p(); rise_p();
    chk("R10 ovf set", {15'b0, ovf}, 16'h1);
    cyc(2);
    chk("R10 ovf sticky", {15'b0, ovf}, 16'h1);
    wreg(2'd2, 16'h0000);
    chk("R9 sw clear flag", {15'b0, flag}, 16'h0);
    chk("R10 sw clear ovf", {15'b0, ovf}, 16'h0);
    wreg(2'd2, 16'h0003);
    chk("R9 sw set", {14'b0, ovf, flag}, 16'h3);
    wreg(2'd2, 16'h0000);
  endtask

  task automatic t_collide();
    logic [15:0] v;
    cap_edge(); fall_p();
    peek(2'd0, snap);
    rd = 1'b1; addr = 2'd1; rise = 1'b1; cyc(1); rd = 1'b0; rise = 1'b0;
    chk("R7 deferred", {15'b0, flag}, 16'h0);
    cyc(1);
    chk("R7 applied flag", {15'b0, flag}, 16'h1);
    peek(2'd1, v); chk("R7 applied ccr", v, snap);
    wreg(2'd2, 16'h0000);
  endtask

  task automatic t_hw_wins();
    cap_edge(); fall_p();
    rise = 1'b1; wreg(2'd2, 16'h0000); rise = 1'b0;
    chk("R9 hw beats sw clear", {15'b0, flag}, 16'h1);
    wreg(2'd2, 16'h0000);
  endtask

  task automatic t_cmp_clear();
    cap_edge(); fall_p();
    cmp = 1'b1; cyc(1); cmp = 1'b0;
    rise_p();
    chk("R6 cmp drops latch", {15'b0, flag}, 16'h0);
  endtask

  task automatic t_compare();
    cmp = 1'b1;
    wreg(2'd1, 16'h0050);
    wreg(2'd0, 16'h004F);
    rise_p();
    chk("R11 no hit", {15'b0, flag}, 16'h0);
    rise_p();
    chk("R11 hit", {15'b0, flag}, 16'h1);
    chk("R11 no ovf", {15'b0, ovf}, 16'h0);
    cmp = 1'b0;
  endtask

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    t_reset();
    t_count();
    t_load();
    t_capture();
    t_nofall();
    t_ovf();
    t_collide();
    t_hw_wins();
    t_cmp_clear();
    t_compare();
    cyc(2);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog act=running exp=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule